// File: doc/BRIEF.md
# Page Write Buffer and Commit Engine

This block gathers the data bytes of one write transaction from a serial-memory front end into a small page-sized staging buffer. When the transaction closes, it commits those bytes to a byte-wide storage array. The front end sends three kinds of strobe. An address strobe carries the starting location. A byte strobe is sent for each received data byte. A commit strobe is sent when the bus stop condition is seen. The front end also raises an abort strobe when a write-protect check refuses the transaction.

The address splits into a page number and an offset inside the page. The page number is held for the whole transaction. Only the offset moves forward as bytes arrive, and it wraps back to the start of the same page. A mask records which offsets hold a byte. At commit, the engine starts one timed write interval with a busy flag raised. During that interval it scans the page and writes only the offsets whose mask bit is set. A read port shows the array contents. Every cell starts at all ones.

Top module: `pwb_engine`

## Requirements
- R1: The address strobe keeps the upper address bits (ADDR_W-4 of them) as the page number and loads the low 4 bits as the offset. Every array write of a commit goes to that page, at offset positions only.
- R2: Each accepted byte is placed at the current offset, and then the offset goes up by one modulo 16. After offset 15 it goes back to offset 0 of the same page. A byte that lands on an offset already loaded replaces the earlier value.
- R3: A commit with at least one byte loaded writes exactly the loaded offsets of the page, each with its latest value. Every other array location stays unchanged.
- R4: The busy flag rises on the clock edge that samples an accepted commit. It stays high for exactly WR_CYCLES clocks. The array holds the new data once busy is low again.
- R5: While busy is high, the address, byte, commit and abort strobes are all ignored.
- R6: A commit with no byte loaded starts no write interval, leaves busy low and writes nothing.
- R7: An abort clears the loaded-offset mask at once and leaves the array untouched. A later commit then writes nothing. An abort in the same cycle as a commit wins, so busy stays low.
- R8: After reset, busy is low and every array location reads FFh.
- R9: When a write interval ends, the mask and the buffer are cleared. A further commit with no new bytes does nothing.
- R10: An address strobe clears the mask. A byte strobe in the same cycle as an address strobe or a commit strobe is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_load | input | 1 | Start-address strobe |
| addr_in | input | ADDR_W | Start address |
| byte_stb | input | 1 | Data-byte strobe |
| byte_in | input | 8 | Data byte |
| commit_stb | input | 1 | Commit request (stop condition) |
| abort_stb | input | 1 | Abort request (write-protect refusal) |
| busy | output | 1 | Write interval in progress |
| mem_we | output | 1 | Array write enable |
| mem_waddr | output | ADDR_W | Array write address |
| mem_wdata | output | 8 | Array write data |
| rd_addr | input | ADDR_W | Array read address |
| rd_data | output | 8 | Array read data (combinational) |

## Verification
Abort and commit can be requested in the same clock, and so can a byte arrival together with an address load or a commit. The bench drives each such pair within a single cycle. It then judges the result only at the ports: whether busy rises, and, after a later clean commit, which array bytes have changed compared with a bench model built from the requirements. A second collision case drives strobes inside a running write interval. The final array image shows that none of them had any effect.

// File: rtl/pwb_pkg.sv
package pwb_pkg;
    localparam int BYTE_W     = 8;
    localparam int PAGE_BYTES = 16;
    localparam int PTR_W      = $clog2(PAGE_BYTES);

    typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/pwb_mem_array.sv
module pwb_mem_array
    import pwb_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  byte_t             wdata,
    input  logic [ADDR_W-1:0] raddr,
    output byte_t             rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    byte_t cell_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                cell_q[i] <= '1;
            end
        end else if (we) begin
            cell_q[waddr] <= wdata;
        end
    end

    assign rdata = cell_q[raddr];
endmodule

// File: rtl/pwb_page_buffer.sv
module pwb_page_buffer
    import pwb_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [PTR_W-1:0] wr_idx,
    input  byte_t            wr_byte,
    input  logic             clr,
    input  logic [PTR_W-1:0] rd_idx,
    output byte_t            rd_byte
);
    byte_t slot_q [PAGE_BYTES];

    for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                slot_q[g] <= '0;
            end else if (clr) begin
                slot_q[g] <= '0;
            end else if (wr_en && (wr_idx == PTR_W'(g))) begin
                slot_q[g] <= wr_byte;
            end
        end
    end

    assign rd_byte = slot_q[rd_idx];
endmodule

// File: rtl/pwb_engine.sv
module pwb_engine
    import pwb_pkg::*;
#(
    parameter int ADDR_W    = 10,
    parameter int WR_CYCLES = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              addr_load,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              byte_stb,
    input  logic [7:0]        byte_in,
    input  logic              commit_stb,
    input  logic              abort_stb,
    output logic              busy,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_waddr,
    output logic [7:0]        mem_wdata,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data
);
    localparam int PAGE_W = ADDR_W - PTR_W;
    localparam int CNT_W  = $clog2(WR_CYCLES + 1);

    typedef struct packed {
        logic [PAGE_W-1:0]     page;
        logic [PTR_W-1:0]      ptr;
        logic [PAGE_BYTES-1:0] valid;
        logic                  busy;
        logic [CNT_W-1:0]      cnt;
    } ctl_t;

    ctl_t             ctl_d, ctl_q;
    logic             buf_we, buf_clr, scan_live;
    logic [PTR_W-1:0] scan_idx;
    byte_t            scan_byte;

    always_comb begin
        ctl_d     = ctl_q;
        buf_we    = 1'b0;
        buf_clr   = 1'b0;
        scan_idx  = ctl_q.cnt[PTR_W-1:0];
        scan_live = ctl_q.busy && (ctl_q.cnt < CNT_W'(PAGE_BYTES));

        if (ctl_q.busy) begin
            if (ctl_q.cnt == CNT_W'(WR_CYCLES - 1)) begin
                ctl_d.busy  = 1'b0;
                ctl_d.cnt   = '0;
                ctl_d.valid = '0;
                buf_clr     = 1'b1;
            end else begin
                ctl_d.cnt = ctl_q.cnt + 1'b1;
            end
        end else if (abort_stb) begin
            ctl_d.valid = '0;
        end else if (addr_load) begin
            ctl_d.page  = addr_in[ADDR_W-1:PTR_W];
            ctl_d.ptr   = addr_in[PTR_W-1:0];
            ctl_d.valid = '0;
        end else if (commit_stb) begin
            if (|ctl_q.valid) begin
                ctl_d.busy = 1'b1;
                ctl_d.cnt  = '0;
            end
        end else if (byte_stb) begin
            buf_we                 = 1'b1;
            ctl_d.valid[ctl_q.ptr] = 1'b1;
            ctl_d.ptr              = ctl_q.ptr + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    pwb_page_buffer u_buf (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (buf_we),
        .wr_idx  (ctl_q.ptr),
        .wr_byte (byte_in),
        .clr     (buf_clr),
        .rd_idx  (scan_idx),
        .rd_byte (scan_byte)
    );

    assign busy      = ctl_q.busy;
    assign mem_we    = scan_live && ctl_q.valid[scan_idx];
    assign mem_waddr = {ctl_q.page, scan_idx};
    assign mem_wdata = scan_byte;

    pwb_mem_array #(.ADDR_W(ADDR_W)) u_mem (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wdata (mem_wdata),
        .raddr (rd_addr),
        .rdata (rd_data)
    );
endmodule

// File: rtl/pwb_engine_chk.sv
module pwb_engine_chk #(
    parameter int ADDR_W    = 10,
    parameter int WR_CYCLES = 40
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              commit_stb,
    input logic              abort_stb,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_waddr
);
    localparam int LEN_W = $clog2(WR_CYCLES + 2);

    logic [LEN_W-1:0] blen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            blen_q <= '0;
        end else if (busy) begin
            blen_q <= blen_q + 1'b1;
        end else begin
            blen_q <= '0;
        end
    end

    AST_BUSY_NEEDS_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(commit_stb)); // R4

    AST_BUSY_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && blen_q != '0) |-> (blen_q == LEN_W'(WR_CYCLES))); // R4

    AST_WRITE_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> busy); // R3

    AST_PAGE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> (mem_waddr[ADDR_W-1:4] == $past(mem_waddr[ADDR_W-1:4]))); // R1

    AST_ABORT_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (abort_stb && !busy) |=> !busy); // R7
endmodule

bind pwb_engine pwb_engine_chk #(.ADDR_W(ADDR_W), .WR_CYCLES(WR_CYCLES)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy       (busy),
    .commit_stb (commit_stb),
    .abort_stb  (abort_stb),
    .mem_we     (mem_we),
    .mem_waddr  (mem_waddr)
);

// File: tb/pwb_engine_test.sv
`timescale 1ns/1ps
module pwb_engine_test;
    localparam int AW   = 10;
    localparam int WRC  = 40;
    localparam int DEPTH = 1 << AW;

    typedef struct packed {
        logic [9:0] a;
        logic [4:0] n;
        logic [7:0] seed;
    } vec_t;

    localparam vec_t VECS [5] = '{
        '{10'h000, 5'd1,  8'h11},
        '{10'h01E, 5'd4,  8'h20},
        '{10'h3F5, 5'd16, 8'h40},
        '{10'h105, 5'd20, 8'h80},
        '{10'h2A0, 5'd3,  8'hC0}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          addr_load = 1'b0;
    logic [AW-1:0] addr_in = '0;
    logic          byte_stb = 1'b0;
    logic [7:0]    byte_in = '0;
    logic          commit_stb = 1'b0;
    logic          abort_stb = 1'b0;
    logic          busy, mem_we;
    logic [AW-1:0] mem_waddr;
    logic [7:0]    mem_wdata;
    logic [AW-1:0] rd_addr = '0;
    logic [7:0]    rd_data;

    int   checks = 0;
    int   fails = 0;
    int   cyc_cnt = 0;
    logic [7:0] shadow [DEPTH];

    pwb_engine #(.ADDR_W(AW), .WR_CYCLES(WRC)) uut (
        .clk(clk), .rst_n(rst_n), .addr_load(addr_load), .addr_in(addr_in),
        .byte_stb(byte_stb), .byte_in(byte_in), .commit_stb(commit_stb),
        .abort_stb(abort_stb), .busy(busy), .mem_we(mem_we),
        .mem_waddr(mem_waddr), .mem_wdata(mem_wdata),
        .rd_addr(rd_addr), .rd_data(rd_data)
    );

    always #10 clk = ~clk;

    always @(posedge clk) begin
        cyc_cnt <= cyc_cnt + 1;
        if (cyc_cnt > 150000) begin
            fails = fails + 1;
            $display("FAIL watchdog: run hung, actual %0d cycles expected < 150000", cyc_cnt);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            fails = fails + 1;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cyc(input logic ld, input logic [AW-1:0] a, input logic bs,
                       input logic [7:0] b, input logic cm, input logic ab);
        addr_load = ld; addr_in = a; byte_stb = bs; byte_in = b;
        commit_stb = cm; abort_stb = ab;
        @(negedge clk);
        addr_load = 1'b0; byte_stb = 1'b0; commit_stb = 1'b0; abort_stb = 1'b0;
    endtask

    task automatic wait_idle(output int n);
        n = 0;
        while (busy && n < 1000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic check_mem(input string req);
        int errs = 0;
        int first_a = 0;
        int first_act = 0;
        int first_exp = 0;
        for (int i = 0; i < DEPTH; i++) begin
            rd_addr = AW'(i);
            #1;
            if (rd_data !== shadow[i]) begin
                if (errs == 0) begin
                    first_a = i; first_act = rd_data; first_exp = shadow[i];
                end
                errs++;
            end
        end
        checks = checks + 1;
        if (errs != 0) begin
            fails = fails + 1;
            $display("FAIL %s: array at %0d actual %0d expected %0d (%0d bad)",
                     req, first_a, first_act, first_exp, errs);
        end
    endtask

    task automatic idle_watch(input int n, input string req);
        int seen = 0;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            if (busy) seen++;
        end
        chk(seen == 0, req, seen, 0);
    endtask

    initial begin
        int n;
        for (int i = 0; i < DEPTH; i++) shadow[i] = 8'hFF;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R8 reset state
        chk(busy == 1'b0, "R8 busy after reset", busy, 0);
        check_mem("R8 array all ones");

        // Vector table: R1 R2 R3 R4
        for (int v = 0; v < 5; v++) begin
            cyc(1'b1, VECS[v].a, 1'b0, 8'h00, 1'b0, 1'b0);
            for (int k = 0; k < int'(VECS[v].n); k++) begin
                logic [3:0] off;
                off = VECS[v].a[3:0] + 4'(k);
                shadow[{VECS[v].a[9:4], off}] = VECS[v].seed + 8'(k);
                cyc(1'b0, '0, 1'b1, VECS[v].seed + 8'(k), 1'b0, 1'b0);
            end
            cyc(1'b0, '0, 1'b0, 8'h00, 1'b1, 1'b0);
            chk(busy == 1'b1, "R4 busy after commit", busy, 1);
            wait_idle(n);
            chk(n == WRC, "R4 busy length", n, WRC);
            check_mem("R1 R2 R3 page image");
        end

        // R6 commit with no bytes
        cyc(1'b1, 10'h050, 1'b0, 8'h00, 1'b0, 1'b0);
        cyc(1'b0, '0, 1'b0, 8'h00, 1'b1, 1'b0);
        idle_watch(5, "R6 empty commit busy");

        // R7 abort then commit
        cyc(1'b1, 10'h060, 1'b0, 8'h00, 1'b0, 1'b0);
        for (int k = 0; k < 3; k++) cyc(1'b0, '0, 1'b1, 8'h33, 1'b0, 1'b0);
        cyc(1'b0, '0, 1'b0, 8'h00, 1'b0, 1'b1);
        cyc(1'b0, '0, 1'b0, 8'h00, 1'b1, 1'b0);
        idle_watch(5, "R7 commit after abort busy");
        // R7 abort together with commit
        cyc(1'b1, 10'h070, 1'b0, 8'h00, 1'b0, 1'b0);
        cyc(1'b0, '0, 1'b1, 8'h44, 1'b0, 1'b0);
        cyc(1'b0, '0, 1'b0, 8'h00, 1'b1, 1'b1);
        idle_watch(3, "R7 abort beats commit");
        cyc(1'b0, '0, 1'b0, 8'h00, 1'b1, 1'b0);
        idle_watch(3, "R7 mask cleared by abort");
        check_mem("R7 array untouched");

        // R5 strobes during busy ignored, then R9
        cyc(1'b1, 10'h200, 1'b0, 8'h00, 1'b0, 1'b0);
        cyc(1'b0, '0, 1'b1, 8'h5A, 1'b0, 1'b0);
        cyc(1'b0, '0, 1'b1, 8'h5B, 1'b0, 1'b0);
        shadow[10'h200] = 8'h5A;
        shadow[10'h201] = 8'h5B;
        cyc(1'b0, '0, 1'b0, 8'h00, 1'b1, 1'b0);
        cyc(1'b1, 10'h300, 1'b0, 8'h00, 1'b0, 1'b0);
        cyc(1'b0, '0, 1'b1, 8'hEE, 1'b0, 1'b0);
        cyc(1'b0, '0, 1'b0, 8'h00, 1'b0, 1'b1);
        cyc(1'b0, '0, 1'b0, 8'h00, 1'b1, 1'b0);
        wait_idle(n);
        chk(n == WRC - 4, "R5 busy not restarted", n, WRC - 4);
        cyc(1'b0, '0, 1'b0, 8'h00, 1'b1, 1'b0);
        idle_watch(4, "R9 commit after completion");
        check_mem("R5 strobes in busy ignored");

        // R10 byte with address load is dropped
        cyc(1'b1, 10'h340, 1'b1, 8'h77, 1'b0, 1'b0);
        cyc(1'b0, '0, 1'b1, 8'h78, 1'b0, 1'b0);
        shadow[10'h340] = 8'h78;
        cyc(1'b0, '0, 1'b0, 8'h00, 1'b1, 1'b0);
        wait_idle(n);
        check_mem("R10 byte with load dropped");

        // R10 byte with commit is dropped
        cyc(1'b1, 10'h360, 1'b0, 8'h00, 1'b0, 1'b0);
        cyc(1'b0, '0, 1'b1, 8'h10, 1'b0, 1'b0);
        shadow[10'h360] = 8'h10;
        cyc(1'b0, '0, 1'b1, 8'h11, 1'b1, 1'b0);
        chk(busy == 1'b1, "R10 commit accepted", busy, 1);
        wait_idle(n);
        check_mem("R10 byte with commit dropped");

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule